// File: doc/BRIEF.md
# Ramp and Servo Converter Controller

This block is the digital half of a counting analog-to-digital converter. It presents an N-bit code to an external DAC and reads a single comparator bit, `cmpAbove`, which is high when the analog input lies above the DAC output. One counter register does the work in both of its operating modes.

In ramp mode, a start request zeroes the code and then raises it by one on every clock. It stops at the first cycle in which the comparator no longer reports the input above the DAC. The code at that moment is copied into a result register, and a one-cycle done pulse is raised. Conversion time grows with the input level, and a full-scale input needs 2^N clocks.

In servo mode, the counter moves up or down by one step every clock toward the input. This lets the code follow a slowly changing signal. The counter stops at zero and at all-ones rather than wrapping.

Top module: `ramp_servo_adc`

## Requirements
- R1: After reset, `dacCode` and `result` are 0, and `done` and `busy` are low.
- R2: A `startReq` seen while idle with `trackMode` low sets `dacCode` to 0 at the next clock edge and raises `busy`.
- R3: During a ramp conversion, each clock edge at which `cmpAbove` is high and `dacCode` is not all-ones increments `dacCode` by exactly 1.
- R4: At the first edge of a ramp at which `cmpAbove` is low, `result` takes the current `dacCode`, and `done` is high for exactly one cycle. `busy` then falls. For an input level v ≤ 2^N−1, `done` rises v+1 clocks after the start edge, with `result` = v.
- R5: If `cmpAbove` is still high when `dacCode` is all-ones, the ramp ends at that edge with `result` all-ones. For an input above full scale, this happens 2^N clocks after the start edge.
- R6: `result` changes only at the edge that raises `done`. It holds its value through idle cycles and through servo mode.
- R7: While a ramp is running, `startReq` pulses and changes on `trackMode` have no effect on the count, on the result or on the conversion time.
- R8: A `startReq` seen while idle with `trackMode` high enters servo mode without clearing `dacCode`. Each following edge adds 1 when `cmpAbove` is high and subtracts 1 when it is low.
- R9: In servo mode, `dacCode` stays at all-ones while `cmpAbove` is high, and stays at 0 while `cmpAbove` is low.
- R10: In servo mode, an edge that sees `trackMode` low returns the block to idle (`busy` low) and leaves `dacCode` unchanged. Start requests during servo mode are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start request, honoured only when idle |
| trackMode | input | 1 | 1 selects servo mode, 0 selects ramp mode; sampled at start, also keeps servo mode alive |
| cmpAbove | input | 1 | Comparator: analog input is above the DAC output |
| dacCode | output | N | Code driven to the external DAC |
| result | output | N | Last ramp conversion result |
| done | output | 1 | One-cycle pulse when a ramp conversion ends |
| busy | output | 1 | High in ramp or servo mode |

## Verification
Two corners are hard to reach from the ports: the counter's upper stop in ramp mode and the all-ones plateau in servo mode. Both need the comparator to keep reporting "above" while the code is already all-ones. The bench models the input as an integer that may exceed full scale. It drives the comparator from that integer against `dacCode`, so an over-range level reaches the upper stop. A sweep of every level from 0 to 2^N, followed by a servo trajectory that runs past both ends of the range, covers the ramp end-points and both clamps.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  // Strobes from the sequencer to the counter datapath
  typedef struct packed {
    logic clear;
    logic up;
    logic down;
    logic capture;
  } stepCmd_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RAMP  = 2'd1,
    PH_SERVO = 2'd2
  } phase_t;
endpackage

// File: rtl/adc_count_path.sv
module adc_count_path
  import adc_ctrl_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  stepCmd_t     cmd,
  output logic [N-1:0] code,
  output logic [N-1:0] result,
  output logic         atTop,
  output logic         atBottom
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      code   <= '0;
      result <= '0;
    end else begin
      if (cmd.clear)      code <= '0;
      else if (cmd.up)    code <= code + ONE;
      else if (cmd.down)  code <= code - ONE;
      if (cmd.capture)    result <= code;
    end
  end

  assign atTop    = &code;
  assign atBottom = ~|code;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     trackMode,
  input  logic     cmpAbove,
  input  logic     atTop,
  input  logic     atBottom,
  output stepCmd_t cmd,
  output logic     done,
  output logic     rampActive,
  output logic     servoActive
);
  phase_t phase, phaseNext;
  logic   doneNext;

  always_comb begin
    phaseNext = phase;
    cmd       = '0;
    doneNext  = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (startReq) begin
          if (trackMode) begin
            phaseNext = PH_SERVO;
          end else begin
            phaseNext = PH_RAMP;
            cmd.clear = 1'b1;
          end
        end
      end
      PH_RAMP: begin
        if (cmpAbove && !atTop) begin
          cmd.up = 1'b1;
        end else begin
          cmd.capture = 1'b1;
          doneNext    = 1'b1;
          phaseNext   = PH_IDLE;
        end
      end
      PH_SERVO: begin
        if (!trackMode)                 phaseNext = PH_IDLE;
        else if (cmpAbove && !atTop)    cmd.up    = 1'b1;
        else if (!cmpAbove && !atBottom) cmd.down = 1'b1;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      phase <= phaseNext;
      done  <= doneNext;
    end
  end

  assign rampActive  = (phase == PH_RAMP);
  assign servoActive = (phase == PH_SERVO);
endmodule

// File: rtl/ramp_servo_adc.sv
module ramp_servo_adc
  import adc_ctrl_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         trackMode,
  input  logic         cmpAbove,
  output logic [N-1:0] dacCode,
  output logic [N-1:0] result,
  output logic         done,
  output logic         busy
);
  stepCmd_t stepCmd;
  logic     atTop, atBottom, rampActive, servoActive;

  adc_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .trackMode  (trackMode),
    .cmpAbove   (cmpAbove),
    .atTop      (atTop),
    .atBottom   (atBottom),
    .cmd        (stepCmd),
    .done       (done),
    .rampActive (rampActive),
    .servoActive(servoActive)
  );

  adc_count_path #(.N(N)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (stepCmd),
    .code    (dacCode),
    .result  (result),
    .atTop   (atTop),
    .atBottom(atBottom)
  );

  assign busy = rampActive | servoActive;
endmodule

// File: rtl/ramp_servo_adc_chk.sv
module ramp_servo_adc_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         startReq,
  input logic         trackMode,
  input logic         cmpAbove,
  input logic [N-1:0] dacCode,
  input logic [N-1:0] result,
  input logic         done,
  input logic         busy,
  input logic         rampActive,
  input logic         servoActive
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq && !trackMode) |=> (dacCode == '0 && busy));

  assert_ramp_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rampActive && cmpAbove && !(&dacCode)) |=> (dacCode == $past(dacCode) + ONE));

  assert_ramp_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rampActive && !cmpAbove) |=> (done && result == $past(dacCode) && !busy));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_top_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rampActive && (&dacCode)) |=> (done && (&result)));

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

  assert_servo_up_R8: assert property (@(posedge clk) disable iff (!rstN)
    (servoActive && trackMode && cmpAbove && !(&dacCode)) |=> (dacCode == $past(dacCode) + ONE));

  assert_servo_down_R8: assert property (@(posedge clk) disable iff (!rstN)
    (servoActive && trackMode && !cmpAbove && (dacCode != '0)) |=> (dacCode == $past(dacCode) - ONE));

  assert_clamp_top_R9: assert property (@(posedge clk) disable iff (!rstN)
    (servoActive && cmpAbove && (&dacCode)) |=> (&dacCode));

  assert_clamp_bottom_R9: assert property (@(posedge clk) disable iff (!rstN)
    (servoActive && !cmpAbove && dacCode == '0) |=> (dacCode == '0));

  assert_servo_exit_R10: assert property (@(posedge clk) disable iff (!rstN)
    (servoActive && !trackMode) |=> (!busy && $stable(dacCode)));
endmodule

bind ramp_servo_adc ramp_servo_adc_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startReq   (startReq),
  .trackMode  (trackMode),
  .cmpAbove   (cmpAbove),
  .dacCode    (dacCode),
  .result     (result),
  .done       (done),
  .busy       (busy),
  .rampActive (rampActive),
  .servoActive(servoActive)
);

// File: tb/sim_ramp_servo_adc.sv
module sim_ramp_servo_adc;
  localparam int N      = 8;
  localparam int FULL   = (1 << N) - 1;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startReq = 1'b0;
  logic         trackMode = 1'b0;
  logic         cmpAbove;
  logic [N-1:0] dacCode, result;
  logic         done, busy;
  int           vin = 0;
  int           total = 0;
  int           bad = 0;
  int           cycles = 0;

  always #(PERIOD/2) clk = ~clk;

  // comparator model: input strictly above DAC level
  always_comb cmpAbove = (vin > int'(dacCode));

  ramp_servo_adc #(.N(N)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .trackMode(trackMode),
    .cmpAbove(cmpAbove), .dacCode(dacCode), .result(result),
    .done(done), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  // ramp conversion of level v; optional disturbance at count 10
  task automatic runRamp(input int v, input bit disturb);
    int  expCode;
    int  count;
    bit  stepOk;
    int  expEnd;
    expEnd  = (v > FULL) ? FULL : v;
    @(negedge clk);
    vin = v;
    startReq = 1'b1;
    trackMode = 1'b0;
    @(negedge clk);
    startReq = 1'b0;
    check(dacCode == 0 && busy, "R2", int'(dacCode), 0);
    count = 0;
    stepOk = 1'b1;
    while (!done && count < FULL + 10) begin
      if (disturb && count == 10) begin
        startReq = 1'b1;
        trackMode = 1'b1;
      end
      @(negedge clk);
      startReq = 1'b0;
      trackMode = 1'b0;
      count++;
      expCode = (count <= expEnd) ? count : expEnd;
      if (!done && int'(dacCode) != expCode) stepOk = 1'b0;
    end
    check(stepOk, "R3", int'(dacCode), expCode);
    if (disturb) check(int'(result) == expEnd && count == expEnd + 1, "R7", int'(result), expEnd);
    else if (v > FULL) check(int'(result) == FULL && count == FULL + 1, "R5", count, FULL + 1);
    else check(int'(result) == expEnd && count == expEnd + 1, "R4", count, expEnd + 1);
    @(negedge clk);
    check(!done && !busy, "R4", int'(done), 0);
  endtask

  initial begin
    int expTrack;
    int held;
    bit trackOk;
    repeat (3) @(negedge clk);
    check(dacCode == 0 && result == 0 && !done && !busy, "R1", int'(dacCode), 0);
    rstN = 1'b1;

    // exhaustive ramp sweep, including one level above full scale
    for (int v = 0; v <= FULL + 1; v++) runRamp(v, 1'b0);

    // disturbance during a ramp
    runRamp(100, 1'b1);

    // result holds while idle and input moves
    runRamp(50, 1'b0);
    vin = 7;
    repeat (5) @(negedge clk);
    check(result == 50 && !done && !busy, "R6", int'(result), 50);

    // enter servo mode from code 50 with input 60
    vin = 60;
    trackMode = 1'b1;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy && dacCode == 50, "R8", int'(dacCode), 50);
    expTrack = 50;
    trackOk = 1'b1;
    for (int i = 0; i < 700; i++) begin
      vin = (i < 300) ? 60 + i : 359 - 2 * (i - 300);
      startReq = (i % 37 == 0);
      if (vin > expTrack) expTrack = (expTrack == FULL) ? FULL : expTrack + 1;
      else                expTrack = (expTrack == 0) ? 0 : expTrack - 1;
      @(negedge clk);
      if (int'(dacCode) != expTrack) trackOk = 1'b0;
      if (i == 299) check(int'(dacCode) == FULL, "R9", int'(dacCode), FULL);
    end
    startReq = 1'b0;
    check(trackOk, "R8", int'(dacCode), expTrack);
    check(dacCode == 0, "R9", int'(dacCode), 0);
    check(result == 50, "R6", int'(result), 50);

    // step up a little then leave servo mode
    vin = 20;
    repeat (5) @(negedge clk);
    check(dacCode == 5, "R8", int'(dacCode), 5);
    held = int'(dacCode);
    trackMode = 1'b0;
    @(negedge clk);
    check(!busy && int'(dacCode) == held, "R10", int'(dacCode), held);
    repeat (3) @(negedge clk);
    check(int'(dacCode) == held && result == 50, "R10", int'(dacCode), held);

    finishRun();
  end
endmodule